// File: doc/BRIEF.md
# PWM Update Event Divider

This block sits next to a PWM period timer. The timer sends one pulse at the end of each of its periods. From those pulses the block makes two strobes. The first is a PWM-cycle strobe, which marks the end of a full PWM cycle. The second is an update strobe, which goes to the interrupt and the buffered-register update logic. How many timer periods lie between strobes depends on two inputs: the operating-mode class and the output style. The two strobes do not always run at the same rate.

Each strobe comes from its own small counter. The counter moves forward on each period pulse. The strobe is issued on the pulse that brings the counter back to zero. A change to either mode input restarts both counters, so that the new rates take effect cleanly. After a reset, both strobes fire on the very first period pulse, so the downstream logic is synchronised at once.

Top module: `pwm_update_divider`

## Requirements
- R1: During reset (`rstN` low) and in the first cycle after it, both strobes are low. This holds even if period pulses arrive during reset.
- R2: Each strobe is registered. A strobe is high only in the cycle that directly follows a cycle in which `periodPulse` was high.
- R3: With `opMode` = 2'b00 (edge class) and `outMode` = 0 (independent or complementary), both strobes fire on every period pulse.
- R4: With `opMode` = 2'b00 and `outMode` = 1 (push-pull), both strobes fire on every second period pulse.
- R5: With `opMode` = 2'b01 (center-aligned) and `outMode` = 0, both strobes fire on every second period pulse.
- R6: With `opMode` = 2'b01 and `outMode` = 1, both strobes fire on every fourth period pulse.
- R7: With `opMode` = 2'b10 (double-update center-aligned class) and `outMode` = 0, `cycleStrobe` fires on every second pulse and `updateStrobe` fires on every pulse.
- R8: With `opMode` = 2'b10 and `outMode` = 1, `cycleStrobe` fires on every fourth pulse and `updateStrobe` fires on every pulse.
- R9: After reset, the first period pulse fires both strobes, whatever the mode inputs are.
- R10: Suppose `opMode` or `outMode` takes a value that differs from its value in the previous cycle. Then in that cycle both counters restart and any period pulse in that cycle is ignored. After that, each strobe first fires on the N-th pulse, where N is its interval in the new mode.
- R11: `opMode` = 2'b11 behaves exactly like 2'b00.
- R12: `cycleStrobe` is never high without `updateStrobe` also being high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| periodPulse | input | 1 | One-cycle pulse at the end of each timer period |
| opMode | input | 2 | Operating-mode class: 00 edge, 01 center-aligned, 10 double-update center-aligned, 11 same as 00 |
| outMode | input | 1 | 0 independent or complementary, 1 push-pull |
| cycleStrobe | output | 1 | End of a PWM cycle |
| updateStrobe | output | 1 | Interrupt and data-update event |

## Verification
The bench targets the following corner cases:
- **Period pulse in the same cycle as a mode change.** A design that counted this pulse would strobe one pulse early in the new mode.
- **Double-update modes, where the two counters diverge.** A design that shared a single counter would drop update strobes, or would fire the cycle strobe on every pulse.
- **Period pulses that arrive while reset is held.** A design that ignored the reset priming would either strobe during reset or miss the first pulse after release.
- **Back-to-back pulses at interval one, and the reserved opMode code.** A design that decoded the reserved code as any other class would produce the wrong strobe rate.

// File: rtl/pwm_div_pkg.sv
package pwm_div_pkg;

  localparam int CNT_W     = 2;
  localparam int NUM_DIV   = 2;
  localparam int IDX_CYCLE = 0;
  localparam int IDX_UPD   = 1;

  typedef enum logic [1:0] {
    OP_EDGE   = 2'b00,
    OP_CENTER = 2'b01,
    OP_DUAL   = 2'b10,
    OP_RSVD   = 2'b11
  } opClass_t;

  typedef struct packed {
    logic                              restart;
    logic                              advance;
    logic [NUM_DIV-1:0][CNT_W-1:0]     lastCnt;
  } divCtrl_t;

  // The terminal count for each strobe is its interval minus one.
  function automatic logic [CNT_W-1:0] cycleLast(opClass_t op, logic pushPull);
    logic [CNT_W-1:0] res;
    case (op)
      OP_CENTER, OP_DUAL: res = pushPull ? CNT_W'(3) : CNT_W'(1);
      default:            res = pushPull ? CNT_W'(1) : CNT_W'(0);
    endcase
    return res;
  endfunction

  function automatic logic [CNT_W-1:0] updLast(opClass_t op, logic pushPull);
    logic [CNT_W-1:0] res;
    case (op)
      OP_CENTER: res = pushPull ? CNT_W'(3) : CNT_W'(1);
      OP_DUAL:   res = CNT_W'(0);
      default:   res = pushPull ? CNT_W'(1) : CNT_W'(0);
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pwm_div_ctrl.sv
module pwm_div_ctrl
  import pwm_div_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     periodPulse,
  input  logic [1:0] opMode,
  input  logic     outMode,
  output divCtrl_t ctrlOut
);

  logic [1:0] prevOp;
  logic       prevOut;
  logic       modeChanged;
  opClass_t   opClass;

  // The previous values are primed from the inputs during reset, so that
  // releasing reset is never mistaken for a mode change.
  always_ff @(posedge clk) begin
    prevOp  <= opMode;
    prevOut <= outMode;
  end

  assign opClass     = opClass_t'(opMode);
  assign modeChanged = rstN && ((opMode != prevOp) || (outMode != prevOut));

  always_comb begin
    ctrlOut.restart            = modeChanged;
    ctrlOut.advance            = rstN && periodPulse && !modeChanged;
    ctrlOut.lastCnt[IDX_CYCLE] = cycleLast(opClass, outMode);
    ctrlOut.lastCnt[IDX_UPD]   = updLast(opClass, outMode);
  end

  // R10: a restart and an advance never happen in the same cycle.
  assert_restart_blocks_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut.restart |-> !ctrlOut.advance);

  // R5/R6: the cycle interval is always at least as long as the update
  // interval. Checked across the two lookup results.
  assert_update_not_slower_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut.lastCnt[IDX_UPD] <= ctrlOut.lastCnt[IDX_CYCLE]);

endmodule

// File: rtl/pwm_div_datapath.sv
module pwm_div_datapath
  import pwm_div_pkg::*;
#(
  parameter int DIVS  = NUM_DIV,
  parameter int WIDTH = CNT_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  divCtrl_t        ctrlIn,
  output logic [DIVS-1:0] strobe
);

  localparam logic [WIDTH-1:0] PRIME = {WIDTH{1'b1}};

  for (genvar i = 0; i < DIVS; i++) begin : g_div
    logic [WIDTH-1:0] cnt;
    logic             strobeQ;
    logic             wrapNow;

    assign wrapNow = cnt >= ctrlIn.lastCnt[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        // The counter is primed to its maximum, so the first pulse wraps it.
        cnt     <= PRIME;
        strobeQ <= 1'b0;
      end else if (ctrlIn.restart) begin
        cnt     <= '0;
        strobeQ <= 1'b0;
      end else if (ctrlIn.advance) begin
        cnt     <= wrapNow ? '0 : cnt + 1'b1;
        strobeQ <= wrapNow;
      end else begin
        strobeQ <= 1'b0;
      end
    end

    assign strobe[i] = strobeQ;

    // R2: a strobe only ever follows an accepted period pulse.
    assert_strobe_needs_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobeQ |-> $past(ctrlIn.advance));

    // R10: a strobe coincides with the counter having just wrapped.
    assert_strobe_leaves_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
      strobeQ |-> (cnt == '0));
  end

endmodule

// File: rtl/pwm_update_divider.sv
module pwm_update_divider
  import pwm_div_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       periodPulse,
  input  logic [1:0] opMode,
  input  logic       outMode,
  output logic       cycleStrobe,
  output logic       updateStrobe
);

  divCtrl_t           ctrl;
  logic [NUM_DIV-1:0] strobes;

  pwm_div_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .periodPulse (periodPulse),
    .opMode      (opMode),
    .outMode     (outMode),
    .ctrlOut     (ctrl)
  );

  pwm_div_datapath #(.DIVS(NUM_DIV), .WIDTH(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrlIn (ctrl),
    .strobe (strobes)
  );

  assign cycleStrobe  = strobes[IDX_CYCLE];
  assign updateStrobe = strobes[IDX_UPD];

  // R12: the cycle strobe implies the update strobe.
  assert_cycle_implies_update_R12: assert property (@(posedge clk) disable iff (!rstN)
    cycleStrobe |-> updateStrobe);

  // R10: the cycle after a mode change is quiet.
  assert_quiet_after_change_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.restart |=> (!cycleStrobe && !updateStrobe));

  // R7/R8: in the double-update class, every accepted pulse yields an update.
  assert_dual_updates_each_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && opMode == 2'b10) |=> updateStrobe);

endmodule

// File: tb/sim_pwm_update_divider.sv
`timescale 1ns/1ps
module sim_pwm_update_divider;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       periodPulse = 1'b0;
  logic [1:0] opMode = 2'b00;
  logic       outMode = 1'b0;
  logic       cycleStrobe, updateStrobe;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  pwm_update_divider u0 (
    .clk(clk), .rstN(rstN), .periodPulse(periodPulse),
    .opMode(opMode), .outMode(outMode),
    .cycleStrobe(cycleStrobe), .updateStrobe(updateStrobe)
  );

  // Behavioural reference: the strobe interval (in pulses) per mode.
  function automatic int intervalOf(bit upd, logic [1:0] op, logic pp);
    if (op == 2'b01) return pp ? 4 : 2;
    if (op == 2'b10) return upd ? 1 : (pp ? 4 : 2);
    return pp ? 2 : 1;
  endfunction

  int   pulsesSeen[2];
  logic [1:0] refOp;
  logic refOut;
  logic expC = 1'b0, expU = 1'b0;
  logic pulseLast = 1'b0;
  bit   started = 0;
  bit   afterReset = 1;

  always @(posedge clk) begin
    started   = 1;
    pulseLast = periodPulse && rstN;
    if (!rstN) begin
      afterReset = 1;
      refOp = opMode; refOut = outMode;
      expC = 0; expU = 0;
    end else if (opMode != refOp || outMode != refOut) begin
      refOp = opMode; refOut = outMode;
      afterReset = 0;
      pulsesSeen[0] = 0; pulsesSeen[1] = 0;
      expC = 0; expU = 0; pulseLast = 0;
    end else if (periodPulse) begin
      if (afterReset) begin
        // R9: the first pulse after reset fires both strobes.
        afterReset = 0;
        pulsesSeen[0] = 0; pulsesSeen[1] = 0;
        expC = 1; expU = 1;
      end else begin
        pulsesSeen[0]++; pulsesSeen[1]++;
        expC = (pulsesSeen[0] % intervalOf(0, refOp, refOut)) == 0;
        expU = (pulsesSeen[1] % intervalOf(1, refOp, refOut)) == 0;
      end
    end else begin
      expC = 0; expU = 0;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (cycleStrobe !== expC) begin
        fails++;
        $display("FAIL %s cycleStrobe actual=%b expected=%b t=%0t", curReq, cycleStrobe, expC, $time);
      end
      checks++;
      if (updateStrobe !== expU) begin
        fails++;
        $display("FAIL %s updateStrobe actual=%b expected=%b t=%0t", curReq, updateStrobe, expU, $time);
      end
      checks++;  // R2: any strobe must follow a pulse
      if ((cycleStrobe || updateStrobe) && !pulseLast) begin
        fails++;
        $display("FAIL R2 strobe without pulse actual=%b%b expected=00", cycleStrobe, updateStrobe);
      end
      checks++;  // R12
      if (cycleStrobe && !updateStrobe) begin
        fails++;
        $display("FAIL R12 cycle without update actual=0 expected=1");
      end
    end
  end

  task automatic pulses(int n, int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) periodPulse <= 1'b1;
      @(negedge clk) periodPulse <= 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic setMode(logic [1:0] op, logic pp);
    @(negedge clk) begin opMode <= op; outMode <= pp; end
    @(negedge clk);
  endtask

  initial begin
    // R1: pulses while reset is held
    curReq = "R1";
    repeat (2) @(negedge clk);
    periodPulse <= 1'b1;
    repeat (2) @(negedge clk);
    periodPulse <= 1'b0;
    rstN <= 1'b1;
    @(negedge clk);

    curReq = "R9"; pulses(1, 1);
    curReq = "R3"; pulses(4, 0); pulses(3, 2);
    curReq = "R4"; setMode(2'b00, 1'b1); pulses(7, 1);
    curReq = "R5"; setMode(2'b01, 1'b0); pulses(6, 0);
    curReq = "R6"; setMode(2'b01, 1'b1); pulses(9, 1); pulses(4, 0);
    curReq = "R7"; setMode(2'b10, 1'b0); pulses(6, 0); pulses(3, 3);
    curReq = "R8"; setMode(2'b10, 1'b1); pulses(10, 0);
    curReq = "R11"; setMode(2'b11, 1'b1); pulses(5, 1);
    setMode(2'b11, 1'b0); pulses(4, 0);

    // R10: mode change in the same cycle as a pulse, then mid-count change
    curReq = "R10";
    setMode(2'b01, 1'b1); pulses(2, 0);
    @(negedge clk) begin opMode <= 2'b10; periodPulse <= 1'b1; end
    @(negedge clk) periodPulse <= 1'b0;
    pulses(5, 0);
    @(negedge clk) begin outMode <= 1'b0; periodPulse <= 1'b1; end
    @(negedge clk) periodPulse <= 1'b0;
    pulses(3, 1);

    // R9: reset with a non-default mode, first pulse fires both
    curReq = "R9";
    @(negedge clk) begin rstN <= 1'b0; opMode <= 2'b01; outMode <= 1'b1; end
    repeat (2) @(negedge clk);
    rstN <= 1'b1;
    @(negedge clk);
    pulses(6, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule